// File: doc/BRIEF.md
# Grouped Fuse Write-Protect Controller

This block controls access to a small array of one-time-programmable fuse words, each 32 bits wide. The most significant bit of a word is a protect flag, and the 31 bits below it hold fuse data. The words alternate between two groups, a system group and a user group. A group becomes closed to programming only when every one of its designated protect flags has been blown. Because the decision is an AND over several interleaved flags, a single stray flag cannot brick the part. The user group also stays writable after the system group has been sealed.

Software reads a word through a registered read port. It asks for bits to be blown through a single-cycle request that carries a word address and a bit mask. Each request is answered one cycle later with an acknowledge pulse or an error pulse. A hide request turns off both reading and programming until the next reset. After reset the controller walks the whole array once to rebuild the two lock states. It refuses programming until that walk is complete. The fuse cells are modelled behaviourally as sticky bits that keep their value through reset.

Top module: `fuse_wp_top`

## Requirements
- R1: Word layout. Bit 31 of a word is its protect flag and bits 30:0 are data. Even word indices belong to the system group and odd indices to the user group. The system flag words are 0, 2, 4, 6 and 8, and the user flag words are 1, 3, 5 and 7. Bit 31 of any other word, such as word 10, has no effect on locking.
- R2: `sysLocked` is 1 only when all five system flag bits are blown. Any proper subset leaves it at 0.
- R3: `usrLocked` is the AND of the four user flag bits and does not depend on the system group. User words accept blows while the system group is locked, up to the point where the user group itself is locked.
- R4: A blow request to a word whose group is locked is refused.
- R5: An accepted blow ORs the mask into the addressed word. Mask bits at 0 leave the corresponding bits unchanged, and blown bits never clear.
- R6: A request presented on a clock edge produces, on the next cycle, a one-cycle `pgmAck` if it was accepted or a one-cycle `pgmErr` if it was refused. A refused request leaves the array unchanged.
- R7: A cycle with `hideReq` high sets `hidden` from the next cycle onward, and only reset clears it. While `hidden` is 1, reads return zero and every blow request is refused.
- R8: After reset, `ready` stays low for 16 cycles while the array is scanned, and requests in that window are refused. Once `ready` is 1, `sysLocked` and `usrLocked` match the fuse contents left over from before the reset.
- R9: `rdData` shows the word at `rdAddr` one cycle after the address is presented. A blow to that same word on that same edge becomes visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddr | input | 4 | Word address for reads |
| rdData | output | 32 | Registered read data, all zeros while hidden |
| pgmReq | input | 1 | Single-cycle blow request |
| pgmAddr | input | 4 | Word address for the blow |
| pgmMask | input | 32 | Bits to blow (1 = blow) |
| hideReq | input | 1 | Hides the array until the next reset |
| hidden | output | 1 | Array is hidden |
| ready | output | 1 | Post-reset scan is complete |
| sysLocked | output | 1 | System group is write-protected |
| usrLocked | output | 1 | User group is write-protected |
| pgmAck | output | 1 | Pulse: the previous request was accepted |
| pgmErr | output | 1 | Pulse: the previous request was refused |

## Verification
The assertions assume that `pgmReq`, `pgmAddr` and `pgmMask` are stable across each clock edge. They also assume that the fuse cells change only through accepted blows, since the array has no reset. The bench drives every input on the falling edge and sends each request as a one-cycle pulse. It never touches the array except through `pgmReq`, and it keeps the fuse contents across its reset pulses so that the rescan is exercised against cells that are already blown.

// File: rtl/fuse_wp_pkg.sv
package fuse_wp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic blowEn;   // accepted blow this cycle
    logic scanEn;   // capture the flag of the scanned word
    logic hideMask; // force read data to zero
  } fuseStrb_t;
endpackage

// File: rtl/fuse_wp_array.sv
module fuse_wp_array #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  localparam int AW = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrMask,
  input  logic [AW-1:0]     rdAddrA,
  output logic [WORD_W-1:0] rdDataA,
  input  logic [AW-1:0]     flagAddr,
  output logic              flagBit
);
  // Behavioural fuse cells: sticky bits, unaffected by reset
  logic [WORD_W-1:0] cells [NUM_WORDS];

  initial begin
    for (int i = 0; i < NUM_WORDS; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wrEn) cells[wrAddr] <= cells[wrAddr] | wrMask;
  end

  assign rdDataA = cells[rdAddrA];
  assign flagBit = cells[flagAddr][WORD_W-1];

  AST_BLOW_SETS: assert property (@(posedge clk)
    wrEn |=> ((cells[$past(wrAddr)] & $past(wrMask)) == $past(wrMask))); // R5
  AST_BITS_KEPT: assert property (@(posedge clk)
    wrEn |=> ((cells[$past(wrAddr)] & $past(cells[wrAddr])) == $past(cells[wrAddr]))); // R5
endmodule

// File: rtl/fuse_wp_datapath.sv
module fuse_wp_datapath
  import fuse_wp_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  parameter int SYS_FLAGS = 5,
  parameter int USR_FLAGS = 4,
  localparam int AW = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fuseStrb_t         strb,
  input  logic [AW-1:0]     scanAddr,
  input  logic [AW-1:0]     pgmAddr,
  input  logic [WORD_W-1:0] pgmMask,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              sysLocked,
  output logic              usrLocked
);
  localparam int FLAG_BIT = WORD_W - 1;

  logic [WORD_W-1:0] wordA;
  logic              scanFlag;
  logic [SYS_FLAGS-1:0] sysFlags;
  logic [USR_FLAGS-1:0] usrFlags;

  fuse_wp_array #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_array (
    .clk     (clk),
    .wrEn    (strb.blowEn),
    .wrAddr  (pgmAddr),
    .wrMask  (pgmMask),
    .rdAddrA (rdAddr),
    .rdDataA (wordA),
    .flagAddr(scanAddr),
    .flagBit (scanFlag)
  );

  // Registered read, zeroed while hidden
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strb.hideMask) rdData <= '0;
    else                   rdData <= wordA;
  end

  // Shadow copies of the protect flags; system words are even, user words odd
  for (genvar i = 0; i < SYS_FLAGS; i++) begin : g_sysFlag
    localparam logic [AW-1:0] WIDX = AW'(2 * i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sysFlags[i] <= 1'b0;
      else if (strb.scanEn && scanAddr == WIDX) sysFlags[i] <= scanFlag;
      else if (strb.blowEn && pgmAddr == WIDX && pgmMask[FLAG_BIT]) sysFlags[i] <= 1'b1;
    end
  end

  for (genvar j = 0; j < USR_FLAGS; j++) begin : g_usrFlag
    localparam logic [AW-1:0] WIDX = AW'(2 * j + 1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) usrFlags[j] <= 1'b0;
      else if (strb.scanEn && scanAddr == WIDX) usrFlags[j] <= scanFlag;
      else if (strb.blowEn && pgmAddr == WIDX && pgmMask[FLAG_BIT]) usrFlags[j] <= 1'b1;
    end
  end

  assign sysLocked = &sysFlags;
  assign usrLocked = &usrFlags;

  AST_READ_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.hideMask |=> (rdData == '0)); // R7
  AST_NO_BLOW_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.blowEn |-> !(pgmAddr[0] ? usrLocked : sysLocked)); // R4
  AST_SYS_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sysLocked && !strb.scanEn) |=> sysLocked); // R2
endmodule

// File: rtl/fuse_wp_ctrl.sv
module fuse_wp_ctrl
  import fuse_wp_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  localparam int AW = $clog2(NUM_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pgmReq,
  input  logic          pgmIsUser,
  input  logic          hideReq,
  input  logic          sysLocked,
  input  logic          usrLocked,
  output fuseStrb_t     strb,
  output logic [AW-1:0] scanAddr,
  output logic          ready,
  output logic          hidden,
  output logic          pgmAck,
  output logic          pgmErr
);
  localparam logic [AW-1:0] LAST_WORD = AW'(NUM_WORDS - 1);

  logic grpLocked;
  logic refuse;

  assign grpLocked = pgmIsUser ? usrLocked : sysLocked;
  assign refuse    = !ready || hidden || grpLocked;

  assign strb.blowEn   = pgmReq && !refuse;
  assign strb.scanEn   = !ready;
  assign strb.hideMask = hidden;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanAddr <= '0;
      ready    <= 1'b0;
      hidden   <= 1'b0;
      pgmAck   <= 1'b0;
      pgmErr   <= 1'b0;
    end else begin
      if (!ready) begin
        scanAddr <= scanAddr + 1'b1;
        if (scanAddr == LAST_WORD) ready <= 1'b1;
      end
      hidden <= hidden | hideReq;
      pgmAck <= pgmReq && !refuse;
      pgmErr <= pgmReq && refuse;
    end
  end

  AST_HIDE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hidden |=> hidden); // R7
  AST_NO_BLOW_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !strb.blowEn); // R8
  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pgmAck && pgmErr)); // R6
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq |=> (pgmAck || pgmErr)); // R6
endmodule

// File: rtl/fuse_wp_top.sv
module fuse_wp_top
  import fuse_wp_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  parameter int SYS_FLAGS = 5,
  parameter int USR_FLAGS = 4,
  localparam int AW = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic              pgmReq,
  input  logic [AW-1:0]     pgmAddr,
  input  logic [WORD_W-1:0] pgmMask,
  input  logic              hideReq,
  output logic              hidden,
  output logic              ready,
  output logic              sysLocked,
  output logic              usrLocked,
  output logic              pgmAck,
  output logic              pgmErr
);
  fuseStrb_t     strb;
  logic [AW-1:0] scanAddr;

  initial begin
    assert (NUM_WORDS >= 2 * SYS_FLAGS && NUM_WORDS >= 2 * USR_FLAGS)
      else $error("flag words do not fit in the array");
  end

  fuse_wp_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pgmReq   (pgmReq),
    .pgmIsUser(pgmAddr[0]),
    .hideReq  (hideReq),
    .sysLocked(sysLocked),
    .usrLocked(usrLocked),
    .strb     (strb),
    .scanAddr (scanAddr),
    .ready    (ready),
    .hidden   (hidden),
    .pgmAck   (pgmAck),
    .pgmErr   (pgmErr)
  );

  fuse_wp_datapath #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W),
    .SYS_FLAGS(SYS_FLAGS), .USR_FLAGS(USR_FLAGS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .scanAddr (scanAddr),
    .pgmAddr  (pgmAddr),
    .pgmMask  (pgmMask),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .sysLocked(sysLocked),
    .usrLocked(usrLocked)
  );
endmodule

// File: tb/fuse_wp_top_bench.sv
module fuse_wp_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        pgmReq = 1'b0;
  logic [3:0]  pgmAddr = '0;
  logic [31:0] pgmMask = '0;
  logic        hideReq = 1'b0;
  logic        hidden, ready, sysLocked, usrLocked, pgmAck, pgmErr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  fuse_wp_top u_fuse_wp_top (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData),
    .pgmReq(pgmReq), .pgmAddr(pgmAddr), .pgmMask(pgmMask),
    .hideReq(hideReq), .hidden(hidden), .ready(ready),
    .sysLocked(sysLocked), .usrLocked(usrLocked),
    .pgmAck(pgmAck), .pgmErr(pgmErr)
  );

  // ---------------- reference model ----------------
  logic [31:0] mMem [16];
  logic [31:0] eRd = '0;
  logic eAck = 0, eErr = 0, eHidden = 0, eReady = 0;
  int   scanCnt = 0;

  initial for (int i = 0; i < 16; i++) mMem[i] = '0;

  function automatic logic modelSysLock();
    logic r = 1'b1;
    for (int k = 0; k < 5; k++) r &= mMem[2*k][31];
    return r;
  endfunction

  function automatic logic modelUsrLock();
    logic r = 1'b1;
    for (int k = 0; k < 4; k++) r &= mMem[2*k+1][31];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      eRd = '0; eAck = 0; eErr = 0; eHidden = 0; eReady = 0; scanCnt = 0;
    end else begin
      logic refused;
      logic lk;
      lk = pgmAddr[0] ? modelUsrLock() : modelSysLock();
      refused = !eReady || eHidden || lk;
      eRd  = eHidden ? 32'h0 : mMem[rdAddr];
      eAck = pgmReq && !refused;
      eErr = pgmReq && refused;
      if (pgmReq && !refused) mMem[pgmAddr] = mMem[pgmAddr] | pgmMask;
      eHidden = eHidden | hideReq;
      if (!eReady) begin
        scanCnt++;
        if (scanCnt == 16) eReady = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    chk("R9 rdData", rdData, eRd);
    chk("R6 pgmAck", {31'b0, pgmAck}, {31'b0, eAck});
    chk("R6 pgmErr", {31'b0, pgmErr}, {31'b0, eErr});
    chk("R7 hidden", {31'b0, hidden}, {31'b0, eHidden});
    chk("R8 ready", {31'b0, ready}, {31'b0, eReady});
    if (eReady) begin
      chk("R2 sysLocked", {31'b0, sysLocked}, {31'b0, modelSysLock()});
      chk("R3 usrLocked", {31'b0, usrLocked}, {31'b0, modelUsrLock()});
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic waitReady();
    for (int n = 0; n < 40 && !ready; n++) @(negedge clk);
  endtask

  // Returns with ack/err of the request visible
  task automatic blow(input logic [3:0] a, input logic [31:0] m);
    pgmReq = 1'b1; pgmAddr = a; pgmMask = m;
    @(negedge clk);
    pgmReq = 1'b0; pgmMask = '0;
  endtask

  task automatic readW(input logic [3:0] a, output logic [31:0] d);
    rdAddr = a;
    @(negedge clk);
    d = rdData;
  endtask

  logic [31:0] rd;

  initial begin
    @(negedge clk);
    chk("R8 reset ready", {31'b0, ready}, 32'h0);
    chk("R7 reset hidden", {31'b0, hidden}, 32'h0);
    chk("R6 reset ack", {31'b0, pgmAck}, 32'h0);
    chk("R9 reset rdData", rdData, 32'h0);
    rstN = 1'b1;
    waitReady();
    chk("R8 ready after scan", {31'b0, ready}, 32'h1);

    // R5: monotonic OR
    blow(4'd10, 32'h0000_00F0);
    chk("R6 ack accepted", {31'b0, pgmAck}, 32'h1);
    blow(4'd10, 32'h0000_0F0F);
    readW(4'd10, rd);
    chk("R5 OR of masks", rd, 32'h0000_0FFF);
    blow(4'd10, 32'h0000_0000);
    readW(4'd10, rd);
    chk("R5 zero mask no change", rd, 32'h0000_0FFF);

    // R1: flag on a non-flag word does not lock
    blow(4'd10, 32'h8000_0000);
    @(negedge clk);
    chk("R1 word10 flag no lock", {31'b0, sysLocked}, 32'h0);

    // R2: partial then full system flags
    blow(4'd0, 32'h8000_0000);
    blow(4'd2, 32'h8000_0000);
    blow(4'd4, 32'h8000_0000);
    blow(4'd6, 32'h8000_0000);
    chk("R2 four of five flags", {31'b0, sysLocked}, 32'h0);
    blow(4'd8, 32'h8000_0000);
    chk("R2 all five flags", {31'b0, sysLocked}, 32'h1);

    // R4/R6: refused blow to a locked system word
    blow(4'd12, 32'h0000_0001);
    chk("R4 locked refuse err", {31'b0, pgmErr}, 32'h1);
    @(negedge clk);
    chk("R6 err one cycle", {31'b0, pgmErr}, 32'h0);
    readW(4'd12, rd);
    chk("R6 refused leaves word", rd, 32'h0);

    // R3: user group writable after system lock
    blow(4'd11, 32'h0000_0055);
    chk("R3 user blow accepted", {31'b0, pgmAck}, 32'h1);
    blow(4'd1, 32'h8000_0000);
    blow(4'd3, 32'h8000_0000);
    blow(4'd5, 32'h8000_0000);
    chk("R3 three of four user flags", {31'b0, usrLocked}, 32'h0);

    // R9: read and blow of the same word on the same edge
    rdAddr = 4'd13; pgmReq = 1'b1; pgmAddr = 4'd13; pgmMask = 32'h7;
    @(negedge clk);
    pgmReq = 1'b0; pgmMask = '0;
    chk("R9 old value same edge", rdData, 32'h0);
    @(negedge clk);
    chk("R9 new value next cycle", rdData, 32'h7);

    // R8: rescan after reset keeps lock states, refuses during scan
    doReset();
    blow(4'd11, 32'h0000_0100);
    chk("R8 refuse during scan", {31'b0, pgmErr}, 32'h1);
    waitReady();
    chk("R8 sys lock restored", {31'b0, sysLocked}, 32'h1);
    chk("R8 usr lock restored", {31'b0, usrLocked}, 32'h0);
    readW(4'd11, rd);
    chk("R6 scan-time refusal left word", rd, 32'h0000_0055);

    // R7: hide
    hideReq = 1'b1;
    @(negedge clk);
    hideReq = 1'b0;
    chk("R7 hidden set", {31'b0, hidden}, 32'h1);
    readW(4'd10, rd);
    chk("R7 hidden read zero", rd, 32'h0);
    blow(4'd15, 32'h0000_0003);
    chk("R7 hidden blow refused", {31'b0, pgmErr}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R7 hidden sticky", {31'b0, hidden}, 32'h1);
    doReset();
    waitReady();
    chk("R7 hidden cleared by reset", {31'b0, hidden}, 32'h0);
    readW(4'd15, rd);
    chk("R7 hidden blow left word", rd, 32'h0);

    // R3: lock user group
    blow(4'd7, 32'h8000_0000);
    chk("R3 user locked", {31'b0, usrLocked}, 32'h1);
    blow(4'd15, 32'h0000_0001);
    chk("R3 user locked refuse", {31'b0, pgmErr}, 32'h1);
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule